// File: doc/BRIEF.md
# Oversampled Serial Receiver with Qualified Start Search

This block receives an asynchronous serial character on a single line, `rxd_in`, that is sampled once per pulse of an oversampling enable, `os_tick`, running at sixteen times the bit rate. While idle it hunts for the start of a character. A low sample counts as a candidate start only when it follows four high samples, and the candidate is kept only if the six samples after it are also low. Once a start has been confirmed, a sixteen-step phase counter fixes every later bit boundary in the character. Each bit, including the start and stop bits, takes the majority of three samples near the middle of the bit.

The character has one start bit, eight data bits sent least significant first, and one stop bit. When the stop bit has been voted, the byte, a framing-error flag and a noise flag are loaded together into an output holding register. The register is presented as a valid/ready stream. `rx_valid` stays high until the host takes the byte with `rx_ready`.

Back-pressure cannot stall the serial line. A character that completes while the previous one is still unread replaces it. If a load and a host read fall in the same cycle, the load wins: `rx_valid` stays high and the new byte is presented.

`rxd_in` is assumed to be already synchronised to `clk`. The oversampling clock enable comes from elsewhere.

Top module: `uart_rx_vote`

## Requirements
- R1: After reset `rx_valid`, `frame_err` and `noise_err` are 0 and `rx_data` is 0x00.
- R2: A low sample is taken as a candidate start (phase step 1) only if the four samples before it were all high. After the receiver is enabled, high samples seen before the enable do not count. A low sample preceded by fewer than four highs starts nothing.
- R3: The six samples at phase steps 2 to 7 must all be low. If any of them is high, the candidate is dropped, the hunt restarts, and no character is produced.
- R4: Each bit lasts 16 samples. With `LATE_WINDOW`=1 (the default) a bit is decided by the majority of the samples at phase steps 9, 10 and 11; with `LATE_WINDOW`=0 it uses steps 8, 9 and 10. Samples at any other step do not affect the byte or the flags.
- R5: A frame is a low start bit, eight data bits with bit 0 first, and a high stop bit. `rx_data` bit i holds the vote of the i-th data bit received.
- R6: `noise_err` is 1 for a character when the three samples of any of its ten bits (start, data or stop) were not all equal. It is 0 for a character in which every bit had three equal samples.
- R7: `frame_err` is 1 for a character whose stop bit voted low. The byte is still delivered.
- R8: After the stop bit's sixteenth sample, the hunt treats the line as if four high samples had just been seen. After a framing error, a next start bit that follows directly, with no high sample in between, is still received.
- R9: `rx_data`, `frame_err`, `noise_err` and `rx_valid` all change on the same clock edge: the edge on which the stop bit's last vote sample is taken. Before that edge `rx_valid` is unchanged.
- R10: `rx_valid` falls on the edge after a cycle with `rx_valid` and `rx_ready` both high. An unread character is overwritten by the next one. If a load and a read coincide, `rx_valid` stays 1 with the new byte.
- R11: While `rx_en` is low no character is produced. Re-enabling clears the record of high samples, so four new high samples are needed before a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| os_tick | input | 1 | Oversampling enable, one pulse per sample (16 per bit) |
| rxd_in | input | 1 | Serial line, synchronous to `clk` |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Byte in holding register not yet taken |
| rx_ready | input | 1 | Host takes the byte when high with `rx_valid` |
| frame_err | output | 1 | Stop bit of held character voted low |
| noise_err | output | 1 | Some bit of held character had disagreeing samples |

## Verification
Two functions can fall in the same cycle: a host read of the held byte and the load of a newly completed character. The bench provokes this by leaving one character unread. It then raises `rx_ready` in exactly the cycle that carries the sample tick of the next character's last stop-bit vote. The result is judged correct only if `rx_valid` is still high afterwards and the port shows the new byte with that character's flags. A following plain read must then drop `rx_valid`.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_RECV   = 2'd2
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_vote.sv
module rx_vote #(
  parameter int RT_PER_BIT  = 16,
  parameter int LATE_WINDOW = 1,
  localparam int RTW        = $clog2(RT_PER_BIT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [RTW-1:0] rt,
  input  logic           sample,
  output logic           done,
  output logic           vbit,
  output logic           split
);
  import uart_rx_pkg::*;

  localparam int FIRST = RT_PER_BIT / 2 + LATE_WINDOW;

  logic s0, s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 1'b0;
      s1 <= 1'b0;
    end else if (take) begin
      if (rt == RTW'(FIRST))     s0 <= sample;
      if (rt == RTW'(FIRST + 1)) s1 <= sample;
    end
  end

  always_comb begin
    done  = take && (rt == RTW'(FIRST + 2));
    vbit  = maj3(s0, s1, sample);
    split = !((s0 == s1) && (s1 == sample));
  end

  // R4
  vote_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rt == RTW'(FIRST + 1)) |=> (s0 == $past(s0)));

endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl #(
  parameter int DATA_BITS   = 8,
  parameter int RT_PER_BIT  = 16,
  parameter int QUAL_ONES   = 4,
  parameter int VERIFY_N    = 6,
  parameter int LATE_WINDOW = 1,
  localparam int RTW        = $clog2(RT_PER_BIT + 1),
  localparam int IW         = $clog2(DATA_BITS + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 os_tick,
  input  logic                 rxd_in,
  output logic                 load,
  output logic [DATA_BITS-1:0] load_data,
  output logic                 load_fe,
  output logic                 load_noise
);
  import uart_rx_pkg::*;

  localparam int STOP_IDX  = DATA_BITS + 1;
  localparam int LAST_VER  = VERIFY_N + 1;

  rx_state_e            state;
  logic [RTW-1:0]       rt;
  logic [QUAL_ONES-1:0] hist;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 noise_acc;
  logic                 step;
  logic                 take;
  logic                 v_done, v_bit, v_split;

  assign step = os_tick && rx_en;
  assign take = step && (state == ST_RECV);

  rx_vote #(
    .RT_PER_BIT (RT_PER_BIT),
    .LATE_WINDOW(LATE_WINDOW)
  ) u_vote (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .rt    (rt),
    .sample(rxd_in),
    .done  (v_done),
    .vbit  (v_bit),
    .split (v_split)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_HUNT;
      rt        <= RTW'(1);
      hist      <= '0;
      idx       <= '0;
      shreg     <= '0;
      noise_acc <= 1'b0;
    end else if (!rx_en) begin
      state     <= ST_HUNT;
      rt        <= RTW'(1);
      hist      <= '0;
      idx       <= '0;
      noise_acc <= 1'b0;
    end else if (os_tick) begin
      hist <= {hist[QUAL_ONES-2:0], rxd_in};
      unique case (state)
        ST_HUNT: begin
          idx       <= '0;
          noise_acc <= 1'b0;
          if (!rxd_in && (&hist)) begin
            state <= ST_VERIFY;
            rt    <= RTW'(2);
          end else begin
            rt <= RTW'(1);
          end
        end
        ST_VERIFY: begin
          if (rxd_in) begin
            state <= ST_HUNT;
            rt    <= RTW'(1);
          end else begin
            rt <= rt + RTW'(1);
            if (rt == RTW'(LAST_VER)) state <= ST_RECV;
          end
        end
        ST_RECV: begin
          if (v_done) begin
            noise_acc <= noise_acc | v_split;
            if (idx != '0 && idx != IW'(STOP_IDX))
              shreg <= {v_bit, shreg[DATA_BITS-1:1]};
          end
          if (rt == RTW'(RT_PER_BIT)) begin
            rt <= RTW'(1);
            if (idx == IW'(STOP_IDX)) begin
              state <= ST_HUNT;
              hist  <= '1;
              idx   <= '0;
            end else begin
              idx <= idx + IW'(1);
            end
          end else begin
            rt <= rt + RTW'(1);
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  always_comb begin
    load       = take && v_done && (idx == IW'(STOP_IDX));
    load_data  = shreg;
    load_fe    = !v_bit;
    load_noise = noise_acc | v_split;
  end

  // R2
  qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && state == ST_HUNT && !rxd_in && !(&hist)) |=> (state == ST_HUNT));

  // R3
  verify_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && state == ST_VERIFY && rxd_in) |=> (state == ST_HUNT && rt == RTW'(1)));

  // R4
  rt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt >= RTW'(1)) && (rt <= RTW'(RT_PER_BIT)));

  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state == ST_HUNT && hist == '0));

endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] load_data,
  input  logic                 load_fe,
  input  logic                 load_noise,
  input  logic                 rx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 frame_err,
  output logic                 noise_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      noise_err <= 1'b0;
    end else if (load) begin
      rx_data   <= load_data;
      rx_valid  <= 1'b1;
      frame_err <= load_fe;
      noise_err <= load_noise;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  // R9
  load_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rx_valid);

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !load) |=> !rx_valid);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> ($stable(rx_data) && $stable(frame_err) && $stable(noise_err)));

endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int DATA_BITS   = 8,
  parameter int RT_PER_BIT  = 16,
  parameter int QUAL_ONES   = 4,
  parameter int VERIFY_N    = 6,
  parameter int LATE_WINDOW = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 os_tick,
  input  logic                 rxd_in,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic                 frame_err,
  output logic                 noise_err
);

  logic                 load;
  logic [DATA_BITS-1:0] load_data;
  logic                 load_fe;
  logic                 load_noise;

  rx_frame_ctl #(
    .DATA_BITS  (DATA_BITS),
    .RT_PER_BIT (RT_PER_BIT),
    .QUAL_ONES  (QUAL_ONES),
    .VERIFY_N   (VERIFY_N),
    .LATE_WINDOW(LATE_WINDOW)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .os_tick   (os_tick),
    .rxd_in    (rxd_in),
    .load      (load),
    .load_data (load_data),
    .load_fe   (load_fe),
    .load_noise(load_noise)
  );

  rx_hold_reg #(
    .DATA_BITS(DATA_BITS)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .load_fe   (load_fe),
    .load_noise(load_noise),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .frame_err (frame_err),
    .noise_err (noise_err)
  );

endmodule

// File: tb/test_uart_rx_vote.sv
module test_uart_rx_vote;

  localparam int W0 = 8;  // first vote sample index (0-based) for LATE_WINDOW=1 -> step 9
  localparam int LOAD_K = W0 + 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd_in = 1'b1;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, frame_err, noise_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  uart_rx_vote i_uart_rx_vote (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd_in(rxd_in),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .frame_err(frame_err), .noise_err(noise_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit in_window(input int k);
    return (k >= W0) && (k <= W0 + 2);
  endfunction

  task automatic tick(input logic v, input logic rdy);
    @(negedge clk);
    rxd_in   = v;
    os_tick  = 1'b1;
    rx_ready = rdy;
    @(negedge clk);
    os_tick  = 1'b0;
    rx_ready = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input logic v, input int n);
    for (int i = 0; i < n; i++) tick(v, 1'b0);
  endtask

  // fb/fk: bit and sample to flip (fb<0: none); rdy_at_load: raise ready on load tick;
  // probe: check timing of valid around the load tick
  task automatic send_frame(input logic [7:0] d, input logic stop_v, input int fb,
                            input int fk, input bit rdy_at_load, input bit probe);
    for (int b = 0; b < 10; b++) begin
      for (int k = 0; k < 16; k++) begin
        logic v;
        v = (b == 0) ? 1'b0 : (b == 9) ? stop_v : d[b-1];
        if (b == fb && k == fk) v = ~v;
        if (probe && b == 9 && k == LOAD_K)
          chk(rx_valid == 1'b0, "R9 valid before load edge", rx_valid, 0);
        tick(v, rdy_at_load && b == 9 && k == LOAD_K);
        if (probe && b == 9 && k == LOAD_K) begin
          chk(rx_valid == 1'b1, "R9 valid on load edge", rx_valid, 1);
          chk(rx_data == d, "R9 data on load edge", rx_data, d);
        end
      end
    end
  endtask

  task automatic host_read();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R10 read clears valid", rx_valid, 0);
  endtask

  task automatic check_char(input string tag, input logic [7:0] d, input bit fe, input bit nz);
    chk(rx_valid == 1'b1, {tag, " valid"}, rx_valid, 1);
    chk(rx_data == d, {tag, " data"}, rx_data, d);
    chk(frame_err == fe, {tag, " frame_err"}, frame_err, fe);
    chk(noise_err == nz, {tag, " noise_err"}, noise_err, nz);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    // R1
    chk(rx_valid == 0 && frame_err == 0 && noise_err == 0, "R1 flags after reset",
        {rx_valid, frame_err, noise_err}, 0);
    chk(rx_data == 8'h00, "R1 data after reset", rx_data, 0);
    rst_n = 1'b1;

    // R11: disabled receiver ignores a complete frame
    idle(1'b1, 6);
    send_frame(8'h5A, 1'b1, -1, 0, 1'b0, 1'b0);
    idle(1'b1, 4);
    chk(rx_valid == 1'b0, "R11 no char while disabled", rx_valid, 0);

    // R2: after enable, only three highs before a low -> nothing
    rxd_in = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    idle(1'b0, 10);
    idle(1'b1, 3);
    idle(1'b0, 16);
    idle(1'b1, 20);
    chk(rx_valid == 1'b0, "R2 unqualified low ignored", rx_valid, 0);

    // R3: high sample at step 4 drops the candidate
    idle(1'b1, 5);
    idle(1'b0, 3);
    idle(1'b1, 30);
    chk(rx_valid == 1'b0, "R3 glitch rejected", rx_valid, 0);

    // R5 R9: clean frame with load-edge probe
    send_frame(8'hA5, 1'b1, -1, 0, 1'b0, 1'b1);
    check_char("R5 clean", 8'hA5, 0, 0);
    host_read();

    // R4: flip outside the window has no effect
    idle(1'b1, 3);
    send_frame(8'h96, 1'b1, 3, 3, 1'b0, 1'b0);
    check_char("R4 outside window", 8'h96, 0, 0);
    host_read();

    // R6: flip inside the window -> noise, byte kept
    send_frame(8'h4C, 1'b1, 5, W0 + 1, 1'b0, 1'b0);
    check_char("R6 noisy bit", 8'h4C, 0, 1);
    host_read();
    send_frame(8'h4D, 1'b1, -1, 0, 1'b0, 1'b0);
    check_char("R6 clean after noisy", 8'h4D, 0, 0);
    host_read();

    // R7 then R8: bad stop, next start with no high in between
    send_frame(8'h3C, 1'b0, -1, 0, 1'b0, 1'b0);
    check_char("R7 framing error", 8'h3C, 1, 0);
    host_read();
    send_frame(8'hC3, 1'b1, -1, 0, 1'b0, 1'b0);
    check_char("R8 after framing error", 8'hC3, 0, 0);
    host_read();

    // R10: overwrite unread byte
    send_frame(8'h11, 1'b1, -1, 0, 1'b0, 1'b0);
    send_frame(8'h22, 1'b1, -1, 0, 1'b0, 1'b0);
    check_char("R10 overwrite", 8'h22, 0, 0);
    // R10: read and load in the same cycle
    send_frame(8'h33, 1'b1, 9, W0, 1'b1, 1'b0);
    check_char("R10 read with load", 8'h33, 0, 1);
    host_read();

    // R11: disable, re-enable needs four fresh highs
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    idle(1'b1, 2);
    idle(1'b0, 12);
    idle(1'b1, 20);
    chk(rx_valid == 1'b0, "R11 two highs after re-enable", rx_valid, 0);

    // random frames
    for (int n = 0; n < 30; n++) begin
      logic [7:0] d;
      logic       stop_v;
      int         fb, fk, gap;
      bit         nz;
      d      = 8'($urandom);
      stop_v = ($urandom % 5) != 0;
      fb     = ($urandom % 2) ? int'($urandom % 10) : -1;
      fk     = int'($urandom % 16);
      if (fb == 0 && fk < 7) fk = 7 + int'($urandom % 9);
      gap    = int'($urandom % 4);
      nz     = (fb >= 0) && in_window(fk);
      send_frame(d, stop_v, fb, fk, 1'b0, 1'b0);
      check_char("R5 R6 R7 R8 random", d, !stop_v, nz);
      if ($urandom % 2) host_read();
      idle(1'b1, gap);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule